// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt events from up to a few dozen sources for a small 8-bit CPU core. Each source has a pending flag, an enable bit, a priority bit and an auto-clear bit. One global enable gates the whole block. Software reaches these bits through a byte-wide register port. The flags latch on every trigger pulse, whether or not the source is enabled. A source can only ask for service when it is enabled and the global enable is set.

When the CPU signals that an instruction has finished, the controller chooses one eligible source. It then raises a registered request carrying the source number and a fixed vector address. The request stays up until the CPU acknowledges it as the call begins. On acknowledge, the granted priority level is marked in service. A return strobe at the end of the handler releases that level again.

A high-priority source may interrupt a low-priority handler. Nothing interrupts a high-priority handler. A low-priority source waits while any handler is active.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register byte reads 0 (all enables, the global enable, the pending, priority and auto-clear bits) and `irq_req` is 0.
- R2: A 1 on `src_trig[i]` sets pending bit i whatever the enables hold. Pending bits read at address 4 (sources 0–7, bit = source) and address 5 (sources 8–12 in bits 4:0).
- R3: A source is eligible only when its pending, enable and global enable bits are all 1. Address 0 holds the global enable in bit 7 and sources 0–6 in bits 6:0. Address 1 holds sources 7–12 in bits 5:0. A pending flag of a disabled source raises no request and stays set.
- R4: With the global enable at 0, no source is granted. A write to address 0 with bit 7 at 0, in the same cycle as `insn_end`, already blocks that cycle's grant.
- R5: A grant occurs only in a cycle with `insn_end` at 1. `irq_req` rises on the following clock edge, with `irq_id` = source number and `irq_vec` = 0x0003 + 8·id. Request, id and vector then hold until `irq_ack`.
- R6: Among eligible sources of the same level, the lowest-numbered source wins. An eligible high-priority source beats any low-priority one. Priority bits sit at addresses 8 and 9, with the same bit layout as the pending bits, where 1 means high.
- R7: While a high-priority handler is in service, nothing is granted. While only a low-priority handler is in service, only high-priority sources can be granted.
- R8: A pulse on `irq_rti` releases the high level if it is in service, otherwise the low level.
- R9: On acknowledge, the granted source's pending bit is cleared if its auto-clear bit is 1. Auto-clear bits sit at addresses 12 and 13, with the same layout as the pending bits. Otherwise the pending bit stays 1.
- R10: A write to a pending byte loads the written bit values. A trigger in the same cycle wins over a written 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: bits 3:2 select the group, bits 1:0 the byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| src_trig | input | NSRC | Per-source trigger pulses |
| insn_end | input | 1 | Instruction boundary, grant point |
| irq_ack | input | 1 | CPU starts the call to the presented vector |
| irq_rti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Request to the CPU |
| irq_id | output | IDW | Granted source number |
| irq_vec | output | ADDR_W | Granted vector address |

## Verification
Every single source is granted alone, which confirms the vector formula and the auto-clear-off behaviour for each source. Every pair of sources is then granted three ways: both low, the higher-numbered one high, and the lower-numbered one high. This separates index order from level order in the selection.

Directed sequences cover the remaining cases:
- stacking low and high handlers, with and without preemption, and their release by return strobes;
- the same-cycle clear of the global enable;
- triggers racing software writes of 0;
- held requests that ignore new, better sources until acknowledged.

// File: rtl/irqc_pkg.sv
// Shared definitions for the priority interrupt controller.
// Assumes at most four register bytes per group (sources + global enable <= 32).
package irqc_pkg;

    typedef enum logic [1:0] {
        GRP_EN   = 2'd0,
        GRP_PEND = 2'd1,
        GRP_PRIO = 2'd2,
        GRP_AUTO = 2'd3
    } grp_e;

    // Pick one byte out of a 32-bit register view.
    function automatic logic [7:0] get_byte(input logic [31:0] v, input logic [1:0] idx);
        return v[idx*8 +: 8];
    endfunction

endpackage

// File: rtl/irqc_regs.sv
// Register file: enables, global enable, pending, priority and auto-clear bits.
// Assumes single-cycle writes; triggers override all writes to pending bits.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NSRC = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic [NSRC-1:0] src_trig,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] prio_o,
    output logic [NSRC-1:0] auto_o,
    output logic            ge_eff_o
);

    localparam int VIEW_W = 32;

    grp_e       grp;
    logic [1:0] byte_sel;

    logic [NSRC-1:0] en_q, pend_q, prio_q, auto_q;
    logic [NSRC-1:0] en_d, pend_d, prio_d, auto_d;
    logic            ge_q, ge_d;

    logic [VIEW_W-1:0] en_view, pend_view, prio_view, auto_view;

    // Address split into group and byte.
    assign grp      = grp_e'(reg_addr[3:2]);
    assign byte_sel = reg_addr[1:0];

    // Global enable next value and early-clear view for the same-cycle grant check.
    always_comb begin
        ge_d = ge_q;
        if (reg_wr && grp == GRP_EN && byte_sel == 2'd0)
            ge_d = reg_wdata[7];
    end
    assign ge_eff_o = ge_q & ~(reg_wr && grp == GRP_EN && byte_sel == 2'd0 && !reg_wdata[7]);

    // Per-source write decode; enable bits skip position 7, which holds the global enable.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int EPOS  = (i < 7) ? i : i + 1;
        localparam int EBYTE = EPOS / 8;
        localparam int EBIT  = EPOS % 8;
        localparam int SBYTE = i / 8;
        localparam int SBIT  = i % 8;

        logic hit_en, hit_pend, hit_prio, hit_auto;
        assign hit_en   = reg_wr && grp == GRP_EN   && byte_sel == 2'(EBYTE);
        assign hit_pend = reg_wr && grp == GRP_PEND && byte_sel == 2'(SBYTE);
        assign hit_prio = reg_wr && grp == GRP_PRIO && byte_sel == 2'(SBYTE);
        assign hit_auto = reg_wr && grp == GRP_AUTO && byte_sel == 2'(SBYTE);

        assign en_d[i]   = hit_en   ? reg_wdata[EBIT] : en_q[i];
        assign prio_d[i] = hit_prio ? reg_wdata[SBIT] : prio_q[i];
        assign auto_d[i] = hit_auto ? reg_wdata[SBIT] : auto_q[i];
        assign pend_d[i] = src_trig[i] |
                           (~ack_clr[i] & (hit_pend ? reg_wdata[SBIT] : pend_q[i]));
    end

    // Read views padded to 32 bits so any byte index stays in range.
    for (genvar p = 0; p < VIEW_W; p++) begin : g_view
        if (p == 7) begin : g_ge
            assign en_view[p] = ge_q;
        end else if (p < 7 && p < NSRC) begin : g_elo
            assign en_view[p] = en_q[p];
        end else if (p > 7 && p - 1 < NSRC) begin : g_ehi
            assign en_view[p] = en_q[p-1];
        end else begin : g_epad
            assign en_view[p] = 1'b0;
        end

        if (p < NSRC) begin : g_s
            assign pend_view[p] = pend_q[p];
            assign prio_view[p] = prio_q[p];
            assign auto_view[p] = auto_q[p];
        end else begin : g_spad
            assign pend_view[p] = 1'b0;
            assign prio_view[p] = 1'b0;
            assign auto_view[p] = 1'b0;
        end
    end

    // Register read multiplexer.
    always_comb begin
        unique case (grp)
            GRP_EN:   reg_rdata = get_byte(en_view,   byte_sel);
            GRP_PEND: reg_rdata = get_byte(pend_view, byte_sel);
            GRP_PRIO: reg_rdata = get_byte(prio_view, byte_sel);
            default:  reg_rdata = get_byte(auto_view, byte_sel);
        endcase
    end

    // State update for all control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ge_q   <= 1'b0;
            pend_q <= '0;
            prio_q <= '0;
            auto_q <= '0;
        end else begin
            en_q   <= en_d;
            ge_q   <= ge_d;
            pend_q <= pend_d;
            prio_q <= prio_d;
            auto_q <= auto_d;
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign prio_o = prio_q;
    assign auto_o = auto_q;

endmodule

// File: rtl/irqc_find.sv
// Lowest-index finder: reports whether any bit is set and the lowest set index.
// Assumes IDW is wide enough to hold NSRC-1.
module irqc_find #(
    parameter int NSRC = 13,
    parameter int IDW  = 4
) (
    input  logic [NSRC-1:0] vec,
    output logic            hit,
    output logic [IDW-1:0]  idx
);

    // Scan from the top so the lowest set index is the last one written.
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDW'(i);
        end
    end

    assign hit = |vec;

endmodule

// File: rtl/irqc_level.sv
// Grant latch and two-level in-service tracking.
// Assumes the CPU acknowledges only while irq_req is high; a stray acknowledge is ignored.
module irqc_level #(
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           insn_end,
    input  logic           hit_hi,
    input  logic [IDW-1:0] id_hi,
    input  logic           hit_lo,
    input  logic [IDW-1:0] id_lo,
    input  logic           ack,
    input  logic           rti,
    output logic           req_o,
    output logic [IDW-1:0] id_o,
    output logic           ack_fire_o,
    output logic           isv_hi_o,
    output logic           isv_lo_o
);

    logic           req_q, lvl_hi_q, isv_hi_q, isv_lo_q;
    logic [IDW-1:0] id_q;
    logic           grant_hi, grant_lo;

    // Boundary grant decisions against the current in-service state.
    assign grant_hi   = insn_end && !req_q && hit_hi && !isv_hi_q;
    assign grant_lo   = insn_end && !req_q && !grant_hi && hit_lo && !isv_hi_q && !isv_lo_q;
    assign ack_fire_o = ack && req_q;

    // Request latch, held until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= 1'b0;
            id_q     <= '0;
            lvl_hi_q <= 1'b0;
        end else if (ack_fire_o) begin
            req_q <= 1'b0;
        end else if (grant_hi) begin
            req_q    <= 1'b1;
            id_q     <= id_hi;
            lvl_hi_q <= 1'b1;
        end else if (grant_lo) begin
            req_q    <= 1'b1;
            id_q     <= id_lo;
            lvl_hi_q <= 1'b0;
        end
    end

    // In-service levels: a return releases first, an acknowledge then marks its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isv_hi_q <= 1'b0;
            isv_lo_q <= 1'b0;
        end else begin
            if (rti) begin
                if (isv_hi_q) isv_hi_q <= 1'b0;
                else          isv_lo_q <= 1'b0;
            end
            if (ack_fire_o) begin
                if (lvl_hi_q) isv_hi_q <= 1'b1;
                else          isv_lo_q <= 1'b1;
            end
        end
    end

    assign req_o    = req_q;
    assign id_o     = id_q;
    assign isv_hi_o = isv_hi_q;
    assign isv_lo_o = isv_lo_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top level: register file, two-level selection and grant/in-service control.
// Assumes NSRC is between 8 and 30 so the global enable sits inside the first enable byte.
module prio_irq_ctrl #(
    parameter int NSRC       = 13,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    localparam int IDW       = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NSRC-1:0]   src_trig,
    input  logic              insn_end,
    input  logic              irq_ack,
    input  logic              irq_rti,
    output logic              irq_req,
    output logic [IDW-1:0]    irq_id,
    output logic [ADDR_W-1:0] irq_vec
);

    logic [NSRC-1:0] en_w, pend_w, prio_w, auto_w;
    logic [NSRC-1:0] elig, cand_hi, cand_lo, ack_clr;
    logic            ge_eff, hit_hi, hit_lo, ack_fire, isv_hi_w, isv_lo_w;
    logic [IDW-1:0]  id_hi, id_lo;

    irqc_regs #(.NSRC(NSRC)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .src_trig (src_trig),
        .ack_clr  (ack_clr),
        .en_o     (en_w),
        .pend_o   (pend_w),
        .prio_o   (prio_w),
        .auto_o   (auto_w),
        .ge_eff_o (ge_eff)
    );

    // Eligibility split by priority level.
    assign elig    = pend_w & en_w & {NSRC{ge_eff}};
    assign cand_hi = elig & prio_w;
    assign cand_lo = elig & ~prio_w;

    irqc_find #(.NSRC(NSRC), .IDW(IDW)) find_hi_i (.vec(cand_hi), .hit(hit_hi), .idx(id_hi));
    irqc_find #(.NSRC(NSRC), .IDW(IDW)) find_lo_i (.vec(cand_lo), .hit(hit_lo), .idx(id_lo));

    irqc_level #(.IDW(IDW)) level_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_end  (insn_end),
        .hit_hi    (hit_hi),
        .id_hi     (id_hi),
        .hit_lo    (hit_lo),
        .id_lo     (id_lo),
        .ack       (irq_ack),
        .rti       (irq_rti),
        .req_o     (irq_req),
        .id_o      (irq_id),
        .ack_fire_o(ack_fire),
        .isv_hi_o  (isv_hi_w),
        .isv_lo_o  (isv_lo_w)
    );

    // Auto-clear mask for the acknowledged source.
    assign ack_clr = ack_fire ? ((NSRC'(1) << irq_id) & auto_w) : '0;

    // Fixed vector per source.
    assign irq_vec = ADDR_W'(VEC_BASE) + ADDR_W'(irq_id) * ADDR_W'(VEC_STRIDE);

endmodule

// File: rtl/irqc_chk.sv
// Property checker for the interrupt controller, bound to the top level.
// Assumes it observes ports plus the pending and in-service state.
module irqc_chk #(
    parameter int NSRC = 13,
    parameter int IDW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [3:0]      reg_addr,
    input logic            wdata_b7,
    input logic [NSRC-1:0] src_trig,
    input logic [NSRC-1:0] pend,
    input logic            insn_end,
    input logic            irq_ack,
    input logic            irq_req,
    input logic [IDW-1:0]  irq_id,
    input logic            isv_hi
);

    // R5: a request only appears after a boundary
    p_req_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(insn_end));

    // R5: request and id hold until acknowledged
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_id)));

    // R4: a same-cycle clear of the global enable blocks the grant
    p_ge_clear_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(reg_wr && reg_addr == 4'd0 && !wdata_b7));

    // R2: a trigger always leaves its pending bit set
    p_trig_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_trig != '0) |=> ((pend & $past(src_trig)) == $past(src_trig)));

    // R7: no grant while a high-priority handler runs
    p_hi_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(isv_hi));

    // R6: the granted id names an existing source
    p_id_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_id) < NSRC));

endmodule

bind prio_irq_ctrl irqc_chk #(.NSRC(NSRC), .IDW(IDW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .wdata_b7(reg_wdata[7]),
    .src_trig(src_trig),
    .pend    (pend_w),
    .insn_end(insn_end),
    .irq_ack (irq_ack),
    .irq_req (irq_req),
    .irq_id  (irq_id),
    .isv_hi  (isv_hi_w)
);

// File: tb/prio_irq_ctrl_tb_top.sv
// Self-checking bench: sweeps single and paired sources, then directed cases.
module prio_irq_ctrl_tb_top;

    localparam int NSRC = 13;
    localparam int IDW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic [NSRC-1:0] src_trig = '0;
    logic            insn_end = 1'b0;
    logic            irq_ack = 1'b0;
    logic            irq_rti = 1'b0;
    logic            irq_req;
    logic [IDW-1:0]  irq_id;
    logic [15:0]     irq_vec;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_trig(src_trig),
        .insn_end(insn_end), .irq_ack(irq_ack), .irq_rti(irq_rti),
        .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic set13(input logic [3:0] base, input logic [12:0] m);
        wr(base, m[7:0]);
        wr(base + 4'd1, {3'b000, m[12:8]});
    endtask

    task automatic set_en(input logic ge, input logic [12:0] m);
        wr(4'd0, {ge, m[6:0]});
        wr(4'd1, {2'b00, m[12:7]});
    endtask

    task automatic trig(input logic [12:0] m);
        @(negedge clk); src_trig = m;
        @(negedge clk); src_trig = '0;
    endtask

    task automatic boundary();
        @(negedge clk); insn_end = 1'b1;
        @(negedge clk); insn_end = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic do_rti();
        @(negedge clk); irq_rti = 1'b1;
        @(negedge clk); irq_rti = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input int id);
        check({tag, " req"}, 32'(irq_req), 32'd1);
        check({tag, " id"},  32'(irq_id),  32'(id));
        check({tag, " vec"}, 32'(irq_vec), 32'(3 + 8 * id));
    endtask

    function automatic int lowest(input logic [12:0] m);
        for (int i = 0; i < 13; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        nerr++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), d);     check("R1 reg lo", 32'(d), 0);
            rd(4'(a + 1), d); check("R1 reg hi", 32'(d), 0);
        end
        check("R1 req", 32'(irq_req), 0);

        // R2, R3: flags latch while disabled, no request
        set_en(1'b1, 13'h0000);
        trig(13'h1FFF);
        rd(4'd4, d); check("R2 pend lo", 32'(d), 32'hFF);
        rd(4'd5, d); check("R2 pend hi", 32'(d), 32'h1F);
        boundary();
        check("R3 disabled no req", 32'(irq_req), 0);
        rd(4'd4, d); check("R3 flag stays", 32'(d), 32'hFF);
        // R4: global enable off masks
        set_en(1'b0, 13'h0040);
        boundary();
        check("R4 ge off no req", 32'(irq_req), 0);
        // R3: only the enabled source is chosen
        set_en(1'b1, 13'h0040);
        boundary();
        expect_grant("R3 only enabled", 6);
        do_ack(); do_rti();
        set13(4'd4, 13'h0);

        // R10: trigger beats a written 0
        set13(4'd4, 13'h0021);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 8'h00; src_trig = 13'h0008;
        @(negedge clk); reg_wr = 1'b0; src_trig = '0;
        rd(4'd4, d); check("R10 trig wins", 32'(d), 32'h08);
        set13(4'd4, 13'h0);

        // R5: grant needs a boundary and holds until acknowledge
        set_en(1'b1, 13'h1FFF);
        trig(13'h0010);
        repeat (3) @(negedge clk);
        check("R5 no boundary", 32'(irq_req), 0);
        boundary();
        expect_grant("R5 grant", 4);
        trig(13'h0001);
        boundary();
        expect_grant("R5 held", 4);
        do_ack();
        check("R5 dropped on ack", 32'(irq_req), 0);
        do_rti();
        set13(4'd4, 13'h0);

        // R4: clear of global enable in the boundary cycle
        trig(13'h0008);
        @(negedge clk); insn_end = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h7F;
        @(negedge clk); insn_end = 1'b0; reg_wr = 1'b0;
        check("R4 same-cycle clear", 32'(irq_req), 0);
        wr(4'd0, 8'hFF);
        boundary();
        expect_grant("R4 re-enabled", 3);
        do_ack(); do_rti();
        set13(4'd4, 13'h0);

        // R5, R9: each source alone; flag stays without auto-clear
        for (int s = 0; s < 13; s++) begin
            set13(4'd4, 13'(1 << s));
            boundary();
            expect_grant("R5 single", s);
            do_ack();
            rd(4'(4 + s / 8), d);
            check("R9 no autoclear keeps flag", 32'(d[s % 8]), 1);
            do_rti();
            set13(4'd4, 13'h0);
        end

        // R6: all pairs under three priority settings
        for (int i = 0; i < 13; i++) begin
            for (int j = i + 1; j < 13; j++) begin
                for (int m = 0; m < 3; m++) begin
                    logic [12:0] pm, pr;
                    int w;
                    pm = 13'((1 << i) | (1 << j));
                    pr = (m == 0) ? 13'h0 : (m == 1) ? 13'(1 << j) : 13'(1 << i);
                    w  = ((pm & pr) != 0) ? lowest(pm & pr) : lowest(pm);
                    set13(4'd4, pm);
                    set13(4'd8, pr);
                    boundary();
                    expect_grant("R6 pair", w);
                    do_ack(); do_rti();
                end
            end
        end
        set13(4'd4, 13'h0);

        // R7, R8, R9: nesting with auto-clear on everything
        set13(4'd12, 13'h1FFF);
        set13(4'd8, 13'h0404);
        trig(13'(1 << 5));
        boundary();
        expect_grant("R7 low first", 5);
        do_ack();
        rd(4'd4, d); check("R9 autoclear", 32'(d[5]), 0);
        trig(13'(1 << 9));
        boundary();
        check("R7 low waits for low", 32'(irq_req), 0);
        trig(13'(1 << 10));
        boundary();
        expect_grant("R7 high preempts low", 10);
        do_ack();
        trig(13'(1 << 2));
        boundary();
        check("R7 high blocks high", 32'(irq_req), 0);
        do_rti();
        boundary();
        expect_grant("R8 release high", 2);
        do_ack();
        do_rti();
        boundary();
        check("R8 low still in service", 32'(irq_req), 0);
        do_rti();
        boundary();
        expect_grant("R8 release low", 9);
        do_ack(); do_rti();
        boundary();
        check("R9 nothing left", 32'(irq_req), 0);

        report();
    end

endmodule